// File: doc/BRIEF.md
# Seven-Segment Character Writer

This block sits between a display command interface and a small display memory. It takes an 8-bit character code and turns it into a seven-segment pattern with a decimal-point bit. It then stores that pattern in the display memory, starting at a pointer it keeps. The pattern is split over one to eight consecutive memory words, and the number of words and the bit positions used depend on how many common lines the panel multiplexes. When the write is done, the pointer has moved past every word it used.

Separate strobes load the multiplex mode, the memory pointer and a point flag. While the point flag is set, every decoded character also lights its decimal point. The block has a single-port write interface to the memory and writes one word per clock. `busy` is high while a character is being stored, and every command that arrives during that time is dropped.

Top module: `seg_char_writer`

## Requirements
- R1: After a synchronous active-low reset, `mode_q` is 0 (static), `ptr_q` is 0, the point flag is clear, and both `busy` and `mem_we` are low.
- R2: Pattern bits are a=bit0, b=bit1, c=bit2, d=bit3, e=bit4, f=bit5, g=bit6 and decimal point=bit7. Codes 0x00 to 0x09 give the digit patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R3: Codes 0x0A to 0x0F give six symbols: minus 40, L 38, H 76, P 73, degree 63, blank 00.
- R4: Any code of 0x10 or above stores an all-zero pattern, decimal point included.
- R5: A `pt_we` strobe loads the point flag from `pt_in`. Pattern bit7 is set for a defined code exactly when the flag is 1.
- R6: Mode 0 (static) writes 8 words. Word k carries pattern bit k in bit0, and bits 3:1 are 0.
- R7: Mode 1 (two commons) writes 4 words. Word k carries pattern bit 2k in bit0 and bit 2k+1 in bit1, and bits 3:2 are 0.
- R8: Mode 2 (three commons) writes 3 words: {a,b,c}, then {d,e,f}, then {g,dp,0} in bits 0 to 2. Bit3 is always 0.
- R9: Mode 3 (four commons) writes 2 words. The first carries a,b,c,d in bits 0 to 3. The second carries f,g,e,dp in bits 0 to 3.
- R10: The writes start in the cycle after a `chr_we` is accepted and come one per cycle at consecutive addresses from `ptr_q`, with `busy` equal to `mem_we`. Afterwards `ptr_q` equals the start plus the word count, modulo 32.
- R11: While `busy` is high, all strobes are ignored. In an idle cycle with `chr_we` high, the other strobes of that cycle are ignored.
- R12: A `mode_we` strobe loads `mode_in` (0 static, 1 two, 2 three, 3 four commons), and the value shows on `mode_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Load multiplex mode |
| mode_in | input | 2 | Multiplex mode code |
| ptr_we | input | 1 | Load memory pointer |
| ptr_in | input | 5 | New pointer value |
| pt_we | input | 1 | Load point flag |
| pt_in | input | 1 | New point flag value |
| chr_we | input | 1 | Decode and store a character |
| chr_in | input | 8 | Character code |
| mem_we | output | 1 | Display memory write enable |
| mem_addr | output | 5 | Display memory address |
| mem_wdata | output | 4 | Display memory write data |
| busy | output | 1 | Character store in progress |
| mode_q | output | 2 | Current multiplex mode |
| ptr_q | output | 5 | Current memory pointer |

## Verification
A strobe takes effect at the next rising edge. Mode, pointer and flag updates can therefore be read one cycle after the strobe. The first memory write of a character is presented in the cycle after its `chr_we`, and word k appears k cycles after that. The updated pointer and the low `busy` show in the cycle right after the last write. The bench drives inputs and samples outputs on falling edges. It walks through the writes one cycle at a time and compares each word, address and enable in the cycle it is due. It then checks that no extra write follows.

// File: rtl/segwr_pkg.sv
// Shared types and helpers for the seven-segment character writer.
// Assumes an 8-bit pattern (seven segments plus point) and 4-bit memory words.
package segwr_pkg;
    localparam int SEG_W  = 8;
    localparam int COM_W  = 4;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'd0,
        MUX_DIV2   = 2'd1,
        MUX_DIV3   = 2'd2,
        MUX_DIV4   = 2'd3
    } mux_mode_t;

    // Number of memory words one character occupies in a mode.
    function automatic logic [STEP_W:0] span_of(input mux_mode_t m);
        case (m)
            MUX_STATIC: span_of = 4'd8;
            MUX_DIV2:   span_of = 4'd4;
            MUX_DIV3:   span_of = 4'd3;
            default:    span_of = 4'd2;
        endcase
    endfunction
endpackage

// File: rtl/seg_decoder.sv
// Character code to seven-segment pattern. Bit order a..g = bits 0..6, point = bit 7.
// Assumes codes above 0x0F are undefined and yield an all-zero pattern.
module seg_decoder
    import segwr_pkg::*;
(
    input  logic [7:0]       code,
    input  logic             point,
    output logic [SEG_W-1:0] pattern
);
    logic [6:0] segs;
    logic       known;

    // Look up the segment set for digits and symbols.
    always_comb begin
        known = 1'b1;
        case (code)
            8'h00: segs = 7'h3F;
            8'h01: segs = 7'h06;
            8'h02: segs = 7'h5B;
            8'h03: segs = 7'h4F;
            8'h04: segs = 7'h66;
            8'h05: segs = 7'h6D;
            8'h06: segs = 7'h7D;
            8'h07: segs = 7'h07;
            8'h08: segs = 7'h7F;
            8'h09: segs = 7'h6F;
            8'h0A: segs = 7'h40;
            8'h0B: segs = 7'h38;
            8'h0C: segs = 7'h76;
            8'h0D: segs = 7'h73;
            8'h0E: segs = 7'h63;
            8'h0F: segs = 7'h00;
            default: begin
                segs  = 7'h00;
                known = 1'b0;
            end
        endcase
    end

    assign pattern = {point & known, segs};
endmodule

// File: rtl/seg_layout.sv
// Picks the memory word for one step of a character store.
// Assumes step is below the span of the mode; unused bit positions are written as 0.
module seg_layout
    import segwr_pkg::*;
(
    input  mux_mode_t         mode,
    input  logic [SEG_W-1:0]  pattern,
    input  logic [STEP_W-1:0] step,
    output logic [COM_W-1:0]  word
);
    logic [1:0] per_word;
    logic [4:0] base;

    // Bits used per word in the modes that fill words in plain order.
    always_comb begin
        case (mode)
            MUX_STATIC: per_word = 2'd1;
            MUX_DIV2:   per_word = 2'd2;
            default:    per_word = 2'd3;
        endcase
    end

    assign base = 5'(step) * 5'(per_word);

    for (genvar b = 0; b < COM_W; b++) begin : g_bit
        localparam int HI_SLOT = (b == 0) ? 5 : (b == 1) ? 6 : (b == 2) ? 4 : 7;
        logic [4:0] slot;
        logic       in_use;
        assign slot   = base + 5'(b);
        assign in_use = ({1'b0, per_word} > 3'(b)) && (slot < 5'd8);
        assign word[b] = (mode == MUX_DIV4) ? (step[0] ? pattern[HI_SLOT] : pattern[b])
                                            : (in_use ? pattern[slot[2:0]] : 1'b0);
    end
endmodule

// File: rtl/segwr_ctrl.sv
// Holds mode, pointer and point flag, and steps a character store over memory words.
// Assumes one memory word is written per clock; commands are dropped while busy.
module segwr_ctrl
    import segwr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  mux_mode_t         mode_in,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic              pt_we,
    input  logic              pt_in,
    input  logic              chr_we,
    input  logic [SEG_W-1:0]  pat_in,
    output mux_mode_t         mode_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              pt_q,
    output logic              busy_q,
    output logic [STEP_W-1:0] step_q,
    output logic [SEG_W-1:0]  pat_q
);
    logic [STEP_W:0] last_step;
    logic            at_last;

    assign last_step = span_of(mode_q) - 1'b1;
    assign at_last   = ({1'b0, step_q} == last_step);

    // Command acceptance and store sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MUX_STATIC;
            ptr_q  <= '0;
            pt_q   <= 1'b0;
            busy_q <= 1'b0;
            step_q <= '0;
            pat_q  <= '0;
        end else if (busy_q) begin
            ptr_q <= ptr_q + 1'b1;
            if (at_last) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end else if (chr_we) begin
            pat_q  <= pat_in;
            busy_q <= 1'b1;
            step_q <= '0;
        end else begin
            if (mode_we) mode_q <= mode_in;
            if (ptr_we)  ptr_q  <= ptr_in;
            if (pt_we)   pt_q   <= pt_in;
        end
    end
endmodule

// File: rtl/seg_char_writer.sv
// Top: decodes a character, then stores it over mode-dependent memory words.
// Assumes a single-port display memory that takes one word per clock.
module seg_char_writer
    import segwr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [1:0]        mode_in,
    input  logic              ptr_we,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic              pt_we,
    input  logic              pt_in,
    input  logic              chr_we,
    input  logic [7:0]        chr_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [COM_W-1:0]  mem_wdata,
    output logic              busy,
    output logic [1:0]        mode_q,
    output logic [ADDR_W-1:0] ptr_q
);
    mux_mode_t         mode_r;
    logic [SEG_W-1:0]  dec_pat;
    logic [SEG_W-1:0]  held_pat;
    logic [STEP_W-1:0] step;
    logic              point_flag;
    logic              busy_r;

    seg_decoder u_dec (
        .code    (chr_in),
        .point   (point_flag),
        .pattern (dec_pat)
    );

    segwr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we),
        .mode_in (mux_mode_t'(mode_in)),
        .ptr_we  (ptr_we),
        .ptr_in  (ptr_in),
        .pt_we   (pt_we),
        .pt_in   (pt_in),
        .chr_we  (chr_we),
        .pat_in  (dec_pat),
        .mode_q  (mode_r),
        .ptr_q   (ptr_q),
        .pt_q    (point_flag),
        .busy_q  (busy_r),
        .step_q  (step),
        .pat_q   (held_pat)
    );

    seg_layout u_lay (
        .mode    (mode_r),
        .pattern (held_pat),
        .step    (step),
        .word    (mem_wdata)
    );

    assign mem_we   = busy_r;
    assign busy     = busy_r;
    assign mem_addr = ptr_q;
    assign mode_q   = mode_r;
endmodule

// File: rtl/seg_char_writer_chk.sv
// Checker bound to the top: word bit limits per mode, pointer stepping, mode hold, burst length.
module seg_char_writer_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr_q,
    input logic [3:0]        mem_wdata,
    input logic              busy,
    input logic [1:0]        mode_q
);
    logic [3:0] run_cnt;

    // Count consecutive write cycles to bound a burst.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= '0;
        else if (mem_we) run_cnt <= run_cnt + 1'b1;
        else             run_cnt <= '0;
    end

    assert_static_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == 2'd0) |-> (mem_wdata[3:1] == 3'b000));
    assert_div2_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == 2'd1) |-> (mem_wdata[3:2] == 2'b00));
    assert_div3_top_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == 2'd2) |-> !mem_wdata[3]);
    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr_q == $past(ptr_q) + 1'b1));
    assert_burst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (run_cnt < 4'd8));
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));
endmodule

bind seg_char_writer seg_char_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .ptr_q     (ptr_q),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .mode_q    (mode_q)
);

// File: tb/sim_seg_char_writer.sv
module sim_seg_char_writer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {mode[1:0], point, start_ptr[4:0], code[7:0]}
    localparam logic [15:0] VEC [NV] = '{
        {2'd3, 1'b1, 5'd0,  8'h06},
        {2'd2, 1'b1, 5'd4,  8'h06},
        {2'd0, 1'b0, 5'd8,  8'h02},
        {2'd1, 1'b1, 5'd16, 8'h09},
        {2'd3, 1'b0, 5'd2,  8'h0A},
        {2'd2, 1'b0, 5'd10, 8'h0B},
        {2'd1, 1'b0, 5'd20, 8'h0C},
        {2'd0, 1'b1, 5'd1,  8'h0D},
        {2'd3, 1'b1, 5'd12, 8'h0E},
        {2'd2, 1'b1, 5'd6,  8'h0F},
        {2'd3, 1'b1, 5'd30, 8'h08},
        {2'd1, 1'b1, 5'd5,  8'h23}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0, ptr_we = 1'b0, pt_we = 1'b0, chr_we = 1'b0, pt_in = 1'b0;
    logic [1:0] mode_in = '0;
    logic [4:0] ptr_in = '0;
    logic [7:0] chr_in = '0;
    logic       mem_we, busy;
    logic [4:0] mem_addr, ptr_q;
    logic [3:0] mem_wdata;
    logic [1:0] mode_q;
    int total = 0;
    int bad = 0;

    seg_char_writer u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
        .ptr_we(ptr_we), .ptr_in(ptr_in), .pt_we(pt_we), .pt_in(pt_in),
        .chr_we(chr_we), .chr_in(chr_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .mode_q(mode_q), .ptr_q(ptr_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pat(input logic [7:0] c, input logic p);
        logic [6:0] s;
        case (c)
            8'h00: s = 7'h3F; 8'h01: s = 7'h06; 8'h02: s = 7'h5B; 8'h03: s = 7'h4F;
            8'h04: s = 7'h66; 8'h05: s = 7'h6D; 8'h06: s = 7'h7D; 8'h07: s = 7'h07;
            8'h08: s = 7'h7F; 8'h09: s = 7'h6F; 8'h0A: s = 7'h40; 8'h0B: s = 7'h38;
            8'h0C: s = 7'h76; 8'h0D: s = 7'h73; 8'h0E: s = 7'h63; 8'h0F: s = 7'h00;
            default: return 8'h00;
        endcase
        return {p, s};
    endfunction

    function automatic int span(input logic [1:0] m);
        return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : (m == 2'd2) ? 3 : 2;
    endfunction

    function automatic logic [3:0] exp_word(input logic [1:0] m, input logic [7:0] p, input int k);
        case (m)
            2'd0: return {3'b000, p[k]};
            2'd1: return {2'b00, p[2*k+1], p[2*k]};
            2'd2: return (k == 0) ? {1'b0, p[2:0]} : (k == 1) ? {1'b0, p[5:3]} : {2'b00, p[7:6]};
            default: return (k == 0) ? p[3:0] : {p[7], p[4], p[6], p[5]};
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] m);
        return (m == 2'd0) ? "R6" : (m == 2'd1) ? "R7" : (m == 2'd2) ? "R8" : "R9";
    endfunction

    // Load mode, pointer and flag in one idle cycle, then read the mode back (R12).
    task automatic setup(input logic [1:0] m, input logic p, input logic [4:0] sp);
        @(negedge clk);
        mode_we = 1'b1; mode_in = m; ptr_we = 1'b1; ptr_in = sp; pt_we = 1'b1; pt_in = p;
        @(negedge clk);
        mode_we = 1'b0; ptr_we = 1'b0; pt_we = 1'b0;
        check("R12 mode load", mode_q, m);
    endtask

    // Strobe a character and check every write in its cycle, then the pointer (R10).
    task automatic store(input logic [1:0] m, input logic [7:0] c, input logic p,
                         input logic [4:0] sp, input string tag);
        logic [7:0] pat;
        pat = exp_pat(c, p);
        chr_we = 1'b1; chr_in = c;
        @(negedge clk);
        chr_we = 1'b0;
        for (int k = 0; k < span(m); k++) begin
            check({"R10 we ", tag}, mem_we, 1'b1);
            check({"R10 addr ", tag}, mem_addr, 5'(sp + 5'(k)));
            check({req_of(m), " word ", tag}, mem_wdata, exp_word(m, pat, k));
            @(negedge clk);
        end
        check({"R10 end we ", tag}, mem_we, 1'b0);
        check({"R10 end busy ", tag}, busy, 1'b0);
        check({"R10 ptr ", tag}, ptr_q, 5'(sp + 5'(span(m))));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode", mode_q, 2'd0);
        check("R1 ptr", ptr_q, 5'd0);
        check("R1 busy", busy, 1'b0);
        check("R1 we", mem_we, 1'b0);
        rst_n = 1'b1;
        // R1 flag clear: a digit stored right after reset has no point (static, 8 words)
        @(negedge clk);
        store(2'd0, 8'h08, 1'b0, 5'd0, "R1 R5 reset flag");

        // Table walk: R2 digits, R3 symbols, R4 undefined code, R5 point, R9 wrap at 30
        for (int i = 0; i < NV; i++) begin
            setup(VEC[i][15:14], VEC[i][13], VEC[i][12:8]);
            store(VEC[i][15:14], VEC[i][7:0], VEC[i][13], VEC[i][12:8],
                  (VEC[i][7:0] > 8'h0F) ? "R4" : (VEC[i][7:0] > 8'h09) ? "R3" : "R2");
        end

        // R10 wrap in static mode from 28 across 31
        setup(2'd0, 1'b1, 5'd28);
        store(2'd0, 8'h05, 1'b1, 5'd28, "R10 wrap");

        // R11: strobes during busy are dropped
        setup(2'd2, 1'b0, 5'd3);
        chr_we = 1'b1; chr_in = 8'h01;
        @(negedge clk);
        chr_in = 8'h07; mode_we = 1'b1; mode_in = 2'd3; ptr_we = 1'b1; ptr_in = 5'd20;
        pt_we = 1'b1; pt_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            check("R11 busy addr", mem_addr, 5'(5'd3 + 5'(k)));
            check("R11 busy word", mem_wdata, exp_word(2'd2, 8'h06, k));
            @(negedge clk);
            if (k == 1) begin
                chr_we = 1'b0; mode_we = 1'b0; ptr_we = 1'b0; pt_we = 1'b0;
            end
        end
        check("R11 no extra write", mem_we, 1'b0);
        check("R11 mode kept", mode_q, 2'd2);
        check("R11 ptr kept", ptr_q, 5'd6);
        // flag must still be clear: store a digit without changing it
        store(2'd2, 8'h08, 1'b0, 5'd6, "R11 flag kept");

        // R11: chr_we in the same idle cycle as other strobes wins
        setup(2'd3, 1'b0, 5'd9);
        chr_we = 1'b1; chr_in = 8'h04; mode_we = 1'b1; mode_in = 2'd0;
        ptr_we = 1'b1; ptr_in = 5'd25; pt_we = 1'b1; pt_in = 1'b1;
        @(negedge clk);
        chr_we = 1'b0; mode_we = 1'b0; ptr_we = 1'b0; pt_we = 1'b0;
        check("R11 same-cycle addr0", mem_addr, 5'd9);
        check("R11 same-cycle word0", mem_wdata, exp_word(2'd3, 8'h66, 0));
        @(negedge clk);
        check("R11 same-cycle word1", mem_wdata, exp_word(2'd3, 8'h66, 1));
        @(negedge clk);
        check("R11 same-cycle mode", mode_q, 2'd3);
        check("R11 same-cycle ptr", ptr_q, 5'd11);
        check("R11 same-cycle done", mem_we, 1'b0);

        // R5: flag cleared again removes the point
        setup(2'd3, 1'b0, 5'd0);
        store(2'd3, 8'h06, 1'b0, 5'd0, "R5 point off");

        // R1: reset mid-store returns to the reset state
        setup(2'd0, 1'b1, 5'd14);
        chr_we = 1'b1; chr_in = 8'h03;
        @(negedge clk);
        chr_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset busy", busy, 1'b0);
        check("R1 mid reset ptr", ptr_q, 5'd0);
        check("R1 mid reset mode", mode_q, 2'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule